// File: doc/BRIEF.md
# CAN Error Count Threshold Interrupt

This block watches the transmit and receive error counters of a CAN controller. It raises a status flag while either counter is above a chosen limit, and it sends a single-cycle interrupt request to the processor when that flag changes in a way that matters.

A select input picks the limit: 96 errors or 128 errors. With the lower limit, only the flag going high produces an interrupt. With the higher limit, the flag going high and the flag going low both produce one. The request is gated by three enables, and all three must be set: the local error enable, the module enable and the global enable. The counters arrive as plain inputs, and the block sees their values one clock late through its registered flag.

Top module: `can_errlim_irq`

## Requirements
- R1: After reset, `over_flag` and `irq` are both 0.
- R2: With `lim_sel` = 0, `over_flag` becomes 1 on the clock edge after either counter is 97 or more. A value of exactly 96 keeps it at 0.
- R3: With `lim_sel` = 1, `over_flag` becomes 1 on the clock edge after either counter is 129 or more. A value of exactly 128 keeps it at 0.
- R4: `over_flag` returns to 0 on the clock edge after both counters are at or below the selected limit.
- R5: `irq` can be 1 only while `err_ie`, `mod_ie` and `glb_ie` are all 1. Clearing any one of them suppresses the request, and `over_flag` behaves as it would otherwise.
- R6: With `lim_sel` = 1 and all enables set, `irq` is 1 in the cycle where `over_flag` goes from 0 to 1, and also in the cycle where it goes from 1 to 0.
- R7: With `lim_sel` = 0, `irq` is 1 only in the cycle where `over_flag` goes from 0 to 1. A 1 to 0 change of the flag produces no request.
- R8: A request lasts exactly one cycle: `irq` is 1 only in the first cycle after `over_flag` changes value, and it returns to 0 the next cycle while the flag stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_cnt | input | 8 | Transmit error counter value |
| rx_cnt | input | 8 | Receive error counter value |
| lim_sel | input | 1 | Limit select: 0 selects 96, 1 selects 128 |
| err_ie | input | 1 | Local error interrupt enable |
| mod_ie | input | 1 | Module interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| over_flag | output | 1 | Threshold-exceeded status |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The block holds only two bits of state: the status flag and its delayed copy.

- **Wrong flag:** this shows at `over_flag` on the very next clock edge after the counter inputs change.
- **Wrong delayed copy:** this shows as a missing, doubled or stretched `irq` pulse in the same cycle as the flag change, or in the cycle after it.

The bench therefore samples both outputs in the first cycle after each stimulus, and again one cycle later. Each limit is approached from exactly at the limit and from one count above it.

// File: rtl/can_errlim_irq.sv
module can_errlim_irq #(
  parameter int CNT_W  = 8,
  parameter int LIM_LO = 96,
  parameter int LIM_HI = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             lim_sel,
  input  logic             err_ie,
  input  logic             mod_ie,
  input  logic             glb_ie,
  output logic             over_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(LIM_LO);
  localparam logic [CNT_W-1:0] HI = CNT_W'(LIM_HI);

  logic [CNT_W-1:0] lim;
  logic             above, flag_q, prev_q, rise, fall, en_all;

  assign lim    = lim_sel ? HI : LO;
  assign above  = (tx_cnt > lim) || (rx_cnt > lim);
  assign rise   = flag_q & ~prev_q;
  assign fall   = ~flag_q & prev_q;
  assign en_all = err_ie & mod_ie & glb_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      flag_q <= above;
      prev_q <= flag_q;
    end
  end

  assign over_flag = flag_q;
  assign irq       = en_all & (rise | (lim_sel & fall));
endmodule

// File: rtl/can_errlim_irq_chk.sv
module can_errlim_irq_chk #(
  parameter int CNT_W  = 8,
  parameter int LIM_LO = 96,
  parameter int LIM_HI = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             lim_sel,
  input logic             err_ie,
  input logic             mod_ie,
  input logic             glb_ie,
  input logic             over_flag,
  input logic             irq
);
  // R2
  lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_sel && (int'(tx_cnt) > LIM_LO || int'(rx_cnt) > LIM_LO)) |=> over_flag);
  // R3
  hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_sel && (int'(tx_cnt) > LIM_HI || int'(rx_cnt) > LIM_HI)) |=> over_flag);
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_sel && int'(tx_cnt) <= LIM_HI && int'(rx_cnt) <= LIM_HI) |=> !over_flag);
  // R5
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err_ie && mod_ie && glb_ie));
  // R6
  both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_sel && err_ie && mod_ie && glb_ie && over_flag != $past(over_flag)) |-> irq);
  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !lim_sel) |-> over_flag);
  // R8
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (over_flag != $past(over_flag)));
endmodule

bind can_errlim_irq can_errlim_irq_chk #(.CNT_W(CNT_W), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .lim_sel(lim_sel),
  .err_ie(err_ie), .mod_ie(mod_ie), .glb_ie(glb_ie), .over_flag(over_flag), .irq(irq)
);

// File: tb/sim_can_errlim_irq.sv
module sim_can_errlim_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_cnt = '0, rx_cnt = '0;
  logic lim_sel = 1'b0, err_ie = 1'b1, mod_ie = 1'b1, glb_ie = 1'b1;
  logic over_flag, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_errlim_irq u0 (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .lim_sel(lim_sel),
    .err_ie(err_ie), .mod_ie(mod_ie), .glb_ie(glb_ie), .over_flag(over_flag), .irq(irq)
  );

  task automatic check(string req, logic f_exp, logic i_exp);
    n_chk++;
    if (over_flag !== f_exp || irq !== i_exp) begin
      n_fail++;
      $display("FAIL %s: over_flag=%b irq=%b expected over_flag=%b irq=%b",
               req, over_flag, irq, f_exp, i_exp);
    end
  endtask

  task automatic drive(logic [7:0] t, logic [7:0] r);
    tx_cnt = t; rx_cnt = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", 1'b0, 1'b0);
  endtask

  task automatic t_low();
    lim_sel = 1'b0; err_ie = 1; mod_ie = 1; glb_ie = 1;
    drive(8'd96, 8'd0);  check("R2", 1'b0, 1'b0);
    drive(8'd97, 8'd0);  check("R2", 1'b1, 1'b1);
    drive(8'd97, 8'd0);  check("R8", 1'b1, 1'b0);
    drive(8'd50, 8'd10); check("R7", 1'b0, 1'b0);
    drive(8'd0, 8'd96);  check("R4", 1'b0, 1'b0);
    drive(8'd0, 8'd255); check("R2", 1'b1, 1'b1);
    drive(8'd96, 8'd96); check("R7", 1'b0, 1'b0);
  endtask

  task automatic t_high();
    lim_sel = 1'b1; err_ie = 1; mod_ie = 1; glb_ie = 1;
    drive(8'd0, 8'd128);   check("R3", 1'b0, 1'b0);
    drive(8'd0, 8'd129);   check("R6", 1'b1, 1'b1);
    drive(8'd200, 8'd129); check("R8", 1'b1, 1'b0);
    drive(8'd128, 8'd128); check("R6", 1'b0, 1'b1);
    drive(8'd128, 8'd128); check("R8", 1'b0, 1'b0);
    drive(8'd129, 8'd0);   check("R3", 1'b1, 1'b1);
    drive(8'd0, 8'd0);     check("R6", 1'b0, 1'b1);
    drive(8'd130, 8'd0);   check("R6", 1'b1, 1'b1);
    drive(8'd0, 8'd0);     check("R4", 1'b0, 1'b1);
  endtask

  task automatic t_gate();
    for (int k = 0; k < 3; k++) begin
      lim_sel = 1'b1;
      err_ie = (k != 0); mod_ie = (k != 1); glb_ie = (k != 2);
      drive(8'd0, 8'd0);   check("R5", 1'b0, 1'b0);
      drive(8'd200, 8'd0); check("R5", 1'b1, 1'b0);
      drive(8'd0, 8'd0);   check("R5", 1'b0, 1'b0);
    end
    err_ie = 1; mod_ie = 1; glb_ie = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low();
    t_high();
    t_gate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule